// File: doc/BRIEF.md
# Four-Channel DMA Request Controller

This block decides which DMA transfer requests are honoured and hands them, one at a time, to an external transfer engine. Each channel holds a mode, a transfer counter, a reload value, a source selection and a pending flag. Requests come from a peripheral request pulse tagged with a source index, or from a software start written through the register write port. Requests that reach a channel that is not ready are discarded.

When one or more channels are pending and no transfer is outstanding, the lowest-numbered eligible channel receives a grant. The grant is held until the engine returns a done pulse. Each completion decrements that channel's counter. In single mode a channel turns itself off when its counter reaches zero. In repeat mode the counter is refilled from the reload value and the channel stays on. Address generation and data movement belong to the engine. The engine is seen here only through the grant and the done pulse.

Software programs the counter, reload value and source while the channel is off. Enabling the mode is the last step. After a select write, the channel needs a short settling window before it accepts requests.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset every mode field is 00, every counter is 0, no pending flag is set and gnt_valid_o is 0.
- R2: Mode fields live at address 0 (channel 0 in bits 1:0, channel 1 in bits 3:2) and address 1 (channel 2 in bits 1:0, channel 3 in bits 3:2). Encoding: 00 off, 01 single, 11 repeat. A channel with 00 or 10 accepts no request.
- R3: Channel c has its select register at address 4+4c, its counter at 4+4c+1 and its reload at 4+4c+2. Counter and reload writes take effect only while the channel mode is 00. Otherwise they are ignored.
- R4: A channel is ready only when its mode is 01 or 11 and its counter is nonzero. A request reaching a channel that is not ready starts no transfer. Its pending flag is 0 on the following cycle.
- R5: Bits 3:0 of the select register hold a source index. A hw_req_i pulse sets a ready channel's pending flag only when hw_src_i equals that index. A non-matching pulse has no effect.
- R6: A select write with bit 7 and bit 5 both set is a software start. It raises the request and leaves the source and the settling window unchanged. A write with only one of the two bits raises no request.
- R7: Any other select write opens a settling window. Requests in the 6 cycles after that write are dropped, as if the channel were off. A request in the 7th cycle is accepted.
- R8: With no transfer outstanding, the lowest-numbered ready pending channel is granted on the next cycle. Issuing the grant clears that channel's pending flag. gnt_valid_o and gnt_ch_o hold until done_i.
- R9: done_i during a grant decrements the granted channel's counter. In single mode, reaching zero sets the mode to 00.
- R10: In repeat mode, reaching zero reloads the counter from the reload register, and the mode stays 11.
- R11: done_i while no grant is outstanding changes no counter and no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (5) | Register write address |
| wr_data_i | input | CNT_W (16) | Register write data |
| hw_req_i | input | 1 | Peripheral request pulse |
| hw_src_i | input | SRC_W (4) | Index of the requesting peripheral |
| done_i | input | 1 | Engine finished the granted transfer |
| gnt_valid_o | output | 1 | A grant is outstanding |
| gnt_ch_o | output | CH_W (2) | Granted channel |
| pending_o | output | NUM_CH (4) | Pending flag per channel |
| mode_o | output | 2*NUM_CH (8) | Mode field per channel, channel c in bits 2c+1:2c |
| count_o | output | NUM_CH*CNT_W (64) | Counter per channel, channel c in bits 16c+15:16c |

## Verification
The following properties are checked on every cycle:
- A channel that is not ready holds no pending flag on the next cycle.
- A new grant never passes over a lower-numbered ready pending channel.
- An outstanding grant stays fixed until done.
- Counters step down correctly.
- Single mode turns the channel off at zero, and repeat mode stays on.
- A stray done pulse leaves every counter unchanged.

Some behaviours only the bench scenarios can show:
- Exact source matching.
- The exact length of the settling window.
- The software-start bit pair, and that a start write preserves the source.
- Ignored counter writes while the channel is enabled.
- The reloaded counter value in repeat mode.
- The full order of grants when several channels wait behind an outstanding transfer.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_REPEAT = 2'b11
  } dma_mode_e;

  localparam int unsigned SEL_SW_BIT  = 7;
  localparam int unsigned SEL_REQ_BIT = 5;
  localparam int unsigned CH_BASE     = 4;
  localparam int unsigned CH_STRIDE   = 4;
  localparam int unsigned OFS_SEL     = 0;
  localparam int unsigned OFS_CNT     = 1;
  localparam int unsigned OFS_RLD     = 2;

  function automatic logic mode_on(input dma_mode_e m);
    return (m == MODE_SINGLE) || (m == MODE_REPEAT);
  endfunction
endpackage

// File: rtl/dma_req_pick.sv
module dma_req_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan
  import dma_req_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned SETTLE = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic [1:0]       mode_i,
  input  logic             sel_wr_i,
  input  logic             sel_start_i,
  input  logic [SRC_W-1:0] sel_src_i,
  input  logic             cnt_wr_i,
  input  logic             rld_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             hw_req_i,
  input  logic [SRC_W-1:0] hw_src_i,
  input  logic             take_i,
  input  logic             done_i,
  output logic             ready_o,
  output logic             pend_o,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned ST_W = $clog2(SETTLE + 1);

  dma_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q, rld_q, cnt_dec;
  logic [SRC_W-1:0] src_q;
  logic [ST_W-1:0]  settle_q;
  logic             pend_q, pend_d;
  logic             sw_start, sel_cfg, req_in, accept_ok;

  assign sw_start  = sel_wr_i & sel_start_i;
  assign sel_cfg   = sel_wr_i & ~sel_start_i;
  assign ready_o   = mode_on(mode_q) && (cnt_q != '0);
  assign accept_ok = ready_o && (settle_q == '0);
  assign req_in    = (hw_req_i && (hw_src_i == src_q)) || sw_start;
  assign cnt_dec   = cnt_q - 1'b1;

  always_comb begin
    pend_d = pend_q;
    if (!ready_o)     pend_d = 1'b0;
    else if (req_in)  pend_d = accept_ok;
    else if (take_i)  pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= '0;
      src_q    <= '0;
    end else if (sel_cfg) begin
      settle_q <= ST_W'(SETTLE);
      src_q    <= sel_src_i;
    end else if (settle_q != '0) begin
      settle_q <= settle_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      cnt_q  <= '0;
      rld_q  <= '0;
    end else begin
      if (done_i && cnt_q != '0) begin
        if (cnt_dec == '0) begin
          if (mode_q == MODE_REPEAT) cnt_q <= rld_q;
          else begin
            cnt_q  <= '0;
            mode_q <= MODE_OFF;
          end
        end else begin
          cnt_q <= cnt_dec;
        end
      end
      if (cnt_wr_i && mode_q == MODE_OFF) cnt_q <= wdata_i;
      if (rld_wr_i && mode_q == MODE_OFF) rld_q <= wdata_i;
      if (mode_wr_i) mode_q <= dma_mode_e'(mode_i);
    end
  end

  assign pend_o = pend_q;
  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned SETTLE = 6,
  parameter int unsigned ADDR_W = $clog2(CH_BASE + CH_STRIDE * NUM_CH),
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [CNT_W-1:0]        wr_data_i,
  input  logic                    hw_req_i,
  input  logic [SRC_W-1:0]        hw_src_i,
  input  logic                    done_i,
  output logic                    gnt_valid_o,
  output logic [CH_W-1:0]         gnt_ch_o,
  output logic [NUM_CH-1:0]       pending_o,
  output logic [2*NUM_CH-1:0]     mode_o,
  output logic [NUM_CH*CNT_W-1:0] count_o
);
  logic [NUM_CH-1:0] ready, pend, cand, take, fin;
  logic              any_cand;
  logic [CH_W-1:0]   pick;
  logic              busy_q;
  logic [CH_W-1:0]   gnt_ch_q;
  logic              sel_start;

  assign sel_start = wr_data_i[SEL_SW_BIT] & wr_data_i[SEL_REQ_BIT];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned BASE = CH_BASE + CH_STRIDE * c;
    logic mode_hit, sel_hit, cnt_hit, rld_hit;
    assign mode_hit = wr_en_i && (wr_addr_i == ADDR_W'(c / 2));
    assign sel_hit  = wr_en_i && (wr_addr_i == ADDR_W'(BASE + OFS_SEL));
    assign cnt_hit  = wr_en_i && (wr_addr_i == ADDR_W'(BASE + OFS_CNT));
    assign rld_hit  = wr_en_i && (wr_addr_i == ADDR_W'(BASE + OFS_RLD));
    assign take[c]  = ~busy_q & any_cand & (pick == CH_W'(c));
    assign fin[c]   = busy_q & done_i & (gnt_ch_q == CH_W'(c));
    assign cand[c]  = pend[c] & ready[c];

    dma_req_chan #(.CNT_W(CNT_W), .SRC_W(SRC_W), .SETTLE(SETTLE)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_wr_i  (mode_hit),
      .mode_i     (wr_data_i[2*(c%2) +: 2]),
      .sel_wr_i   (sel_hit),
      .sel_start_i(sel_start),
      .sel_src_i  (wr_data_i[SRC_W-1:0]),
      .cnt_wr_i   (cnt_hit),
      .rld_wr_i   (rld_hit),
      .wdata_i    (wr_data_i),
      .hw_req_i   (hw_req_i),
      .hw_src_i   (hw_src_i),
      .take_i     (take[c]),
      .done_i     (fin[c]),
      .ready_o    (ready[c]),
      .pend_o     (pend[c]),
      .mode_o     (mode_o[2*c +: 2]),
      .cnt_o      (count_o[c*CNT_W +: CNT_W])
    );
  end

  dma_req_pick #(.N(NUM_CH), .IDX_W(CH_W)) u_pick (
    .req_i(cand),
    .any_o(any_cand),
    .idx_o(pick)
  );

  // single outstanding grant; a new one may start the cycle after done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      gnt_ch_q <= '0;
    end else if (busy_q) begin
      if (done_i) busy_q <= 1'b0;
    end else if (any_cand) begin
      busy_q   <= 1'b1;
      gnt_ch_q <= pick;
    end
  end

  assign gnt_valid_o = busy_q;
  assign gnt_ch_o    = gnt_ch_q;
  assign pending_o   = pend;
endmodule

// File: rtl/dma_req_chk.sv
module dma_req_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CH_W   = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [ADDR_W-1:0]       wr_addr_i,
  input logic                    done_i,
  input logic                    gnt_valid_o,
  input logic [CH_W-1:0]         gnt_ch_o,
  input logic [NUM_CH-1:0]       pending_o,
  input logic [2*NUM_CH-1:0]     mode_o,
  input logic [NUM_CH*CNT_W-1:0] count_o
);
  logic [1:0]       md [NUM_CH];
  logic [CNT_W-1:0] ct [NUM_CH];
  logic [NUM_CH-1:0] rdy, cand_q, lower_mask;
  logic [1:0]       cur_md;
  logic [CNT_W-1:0] cur_ct, prev_ct_q;
  logic [CH_W-1:0]  ch_q;
  logic             mode_wr_cur;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_v
    assign md[c]  = mode_o[2*c +: 2];
    assign ct[c]  = count_o[c*CNT_W +: CNT_W];
    assign rdy[c] = (md[c] == 2'b01 || md[c] == 2'b11) && ct[c] != '0;

    assert_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rdy[c] |=> !pending_o[c]);
  end

  assign cur_md      = md[gnt_ch_o];
  assign cur_ct      = ct[gnt_ch_o];
  assign lower_mask  = (NUM_CH'(1) << gnt_ch_o) - NUM_CH'(1);
  assign mode_wr_cur = wr_en_i && (wr_addr_i == ADDR_W'(gnt_ch_o >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q    <= '0;
      ch_q      <= '0;
      prev_ct_q <= '0;
    end else begin
      cand_q    <= pending_o & rdy;
      ch_q      <= gnt_ch_o;
      prev_ct_q <= cur_ct;
    end
  end

  assert_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_valid_o) |-> cand_q[gnt_ch_o] && ((cand_q & lower_mask) == '0));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o && !done_i |=> gnt_valid_o && $stable(gnt_ch_o));

  assert_dec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o && done_i && cur_md != 2'b00 && cur_ct > CNT_W'(1)
    |=> ct[ch_q] == prev_ct_q - CNT_W'(1));

  assert_single_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o && done_i && cur_md == 2'b01 && cur_ct == CNT_W'(1) && !mode_wr_cur
    |=> md[ch_q] == 2'b00);

  assert_repeat_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o && done_i && cur_md == 2'b11 && cur_ct == CNT_W'(1) && !mode_wr_cur
    |=> md[ch_q] == 2'b11);

  assert_idle_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_valid_o && done_i && !wr_en_i |=> count_o == $past(count_o));
endmodule

bind dma_req_ctrl dma_req_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .done_i     (done_i),
  .gnt_valid_o(gnt_valid_o),
  .gnt_ch_o   (gnt_ch_o),
  .pending_o  (pending_o),
  .mode_o     (mode_o),
  .count_o    (count_o)
);

// File: tb/sim_dma_req_ctrl.sv
`timescale 1ns/1ps
module sim_dma_req_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        hw_req = 1'b0;
  logic [3:0]  hw_src = '0;
  logic        done = 1'b0;
  logic        gnt_valid;
  logic [1:0]  gnt_ch;
  logic [3:0]  pending;
  logic [7:0]  mode;
  logic [63:0] count;

  int total = 0;
  int bad = 0;
  logic [1:0] mode_sh [4];

  always #4 clk = ~clk;

  dma_req_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hw_req_i(hw_req), .hw_src_i(hw_src), .done_i(done),
    .gnt_valid_o(gnt_valid), .gnt_ch_o(gnt_ch), .pending_o(pending),
    .mode_o(mode), .count_o(count)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  md;
    logic [3:0]  src;
    logic [3:0]  pulse;
    logic [15:0] cnt;
    logic        exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 2'b01, 4'd3,  4'd3,  16'd3, 1'b1},
    '{2'd0, 2'b01, 4'd3,  4'd4,  16'd3, 1'b0},
    '{2'd1, 2'b11, 4'd7,  4'd7,  16'd3, 1'b1},
    '{2'd2, 2'b00, 4'd0,  4'd0,  16'd3, 1'b0},
    '{2'd3, 2'b10, 4'd15, 4'd15, 16'd3, 1'b0},
    '{2'd3, 2'b11, 4'd9,  4'd9,  16'd3, 1'b1},
    '{2'd2, 2'b01, 4'd5,  4'd5,  16'd3, 1'b1},
    '{2'd1, 2'b01, 4'd2,  4'd2,  16'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] s);
    hw_req = 1'b1; hw_src = s;
    @(negedge clk);
    hw_req = 1'b0; hw_src = '0;
  endtask

  task automatic fin();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m);
    int r;
    mode_sh[ch] = m;
    r = ch / 2;
    wr(5'(r), {12'd0, mode_sh[2*r+1], mode_sh[2*r]});
  endtask

  task automatic all_off();
    for (int c = 0; c < 4; c++) mode_sh[c] = 2'b00;
    wr(5'd0, 16'd0);
    wr(5'd1, 16'd0);
  endtask

  task automatic setup_ch(input int ch, input logic [15:0] cnt, input logic [15:0] rld,
                          input logic [3:0] src, input logic [1:0] m);
    wr(5'(4 + 4*ch + 1), cnt);
    wr(5'(4 + 4*ch + 2), rld);
    wr(5'(4 + 4*ch), {12'd0, src});
    cyc(6);
    set_mode(ch, m);
  endtask

  task automatic xfer(input logic [3:0] s);
    pulse(s);
    cyc(1);
    fin();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] snap;
    for (int c = 0; c < 4; c++) mode_sh[c] = 2'b00;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    chk("R1 mode", 64'(mode), 64'd0);
    chk("R1 count", count, 64'd0);
    chk("R1 pending", 64'(pending), 64'd0);
    chk("R1 grant", 64'(gnt_valid), 64'd0);

    // table walk: R2 R4 R5 acceptance by mode, count and source
    for (int i = 0; i < 8; i++) begin
      all_off();
      setup_ch(int'(VEC[i].ch), VEC[i].cnt, VEC[i].cnt, VEC[i].src, VEC[i].md);
      pulse(VEC[i].pulse);
      chk($sformatf("R5/R4/R2 vec%0d pending", i), 64'(pending[VEC[i].ch]), 64'(VEC[i].exp));
      cyc(1);
      chk($sformatf("R8 vec%0d grant", i), 64'(gnt_valid), 64'(VEC[i].exp));
      if (VEC[i].exp) begin
        chk($sformatf("R8 vec%0d channel", i), 64'(gnt_ch), 64'(VEC[i].ch));
        fin();
      end
    end

    // R3 counter write ignored while enabled
    all_off();
    setup_ch(0, 16'd5, 16'd5, 4'd1, 2'b01);
    wr(5'd5, 16'd9);
    chk("R3 count locked", 64'(count[15:0]), 64'd5);
    set_mode(0, 2'b00);
    wr(5'd5, 16'd9);
    chk("R3 count written when off", 64'(count[15:0]), 64'd9);

    // R6 software start pair
    all_off();
    setup_ch(0, 16'd10, 16'd10, 4'd3, 2'b01);
    wr(5'd4, 16'h0083);
    chk("R6 bit7 alone", 64'(pending[0]), 64'd0);
    wr(5'd4, 16'h0023);
    chk("R6 bit5 alone", 64'(pending[0]), 64'd0);
    cyc(7);
    wr(5'd4, 16'h00A5);
    chk("R6 start pair", 64'(pending[0]), 64'd1);
    cyc(1);
    chk("R6 start grant", 64'({gnt_valid, gnt_ch}), 64'b100);
    fin();
    pulse(4'd3);
    chk("R6 source kept", 64'(pending[0]), 64'd1);
    cyc(1);
    fin();

    // R7 settling window
    all_off();
    setup_ch(0, 16'd10, 16'd10, 4'd2, 2'b01);
    wr(5'd4, 16'h0002);
    for (int j = 1; j <= 6; j++) begin
      pulse(4'd2);
      chk($sformatf("R7 window cycle %0d", j), 64'(pending[0]), 64'd0);
    end
    pulse(4'd2);
    chk("R7 after window", 64'(pending[0]), 64'd1);
    cyc(1);
    fin();

    // R8 priority and single outstanding grant
    all_off();
    setup_ch(1, 16'd5, 16'd5, 4'd1, 2'b01);
    setup_ch(2, 16'd5, 16'd5, 4'd2, 2'b01);
    setup_ch(3, 16'd5, 16'd5, 4'd4, 2'b01);
    pulse(4'd4);
    cyc(1);
    chk("R8 first grant", 64'({gnt_valid, gnt_ch}), 64'b111);
    pulse(4'd2);
    pulse(4'd1);
    chk("R8 both waiting", 64'(pending), 64'b0110);
    chk("R8 grant held", 64'({gnt_valid, gnt_ch}), 64'b111);
    fin();
    chk("R8 released", 64'(gnt_valid), 64'd0);
    chk("R9 decrement", 64'(count[63:48]), 64'd4);
    cyc(1);
    chk("R8 lowest next", 64'({gnt_valid, gnt_ch}), 64'b101);
    chk("R8 grant clears pending", 64'(pending), 64'b0100);
    fin();
    cyc(1);
    chk("R8 then ch2", 64'({gnt_valid, gnt_ch}), 64'b110);
    fin();

    // R9 single mode runs out
    all_off();
    setup_ch(0, 16'd2, 16'd2, 4'd6, 2'b01);
    xfer(4'd6);
    chk("R9 count 1", 64'(count[15:0]), 64'd1);
    chk("R9 still on", 64'(mode[1:0]), 64'b01);
    xfer(4'd6);
    chk("R9 count 0", 64'(count[15:0]), 64'd0);
    chk("R9 mode off", 64'(mode[1:0]), 64'b00);
    pulse(4'd6);
    chk("R4 exhausted drop", 64'(pending[0]), 64'd0);
    cyc(1);
    chk("R4 no grant", 64'(gnt_valid), 64'd0);

    // R10 repeat mode reload
    all_off();
    setup_ch(1, 16'd2, 16'd7, 4'd8, 2'b11);
    xfer(4'd8);
    xfer(4'd8);
    chk("R10 reloaded", 64'(count[31:16]), 64'd7);
    chk("R10 stays repeat", 64'(mode[3:2]), 64'b11);

    // R11 stray done
    snap = count;
    fin();
    chk("R11 counts unchanged", count, snap);
    chk("R11 modes unchanged", 64'(mode[3:2]), 64'b11);
    chk("R11 no grant", 64'(gnt_valid), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule